// File: doc/BRIEF.md
# Packed SIMD Add/Compare Unit

This block is a 64-bit packed-integer execution unit. Each operand is divided into lanes, and the lane width is chosen on every operation: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes.

In one operation the unit can do any of the following:
- add or subtract all lanes at once, with either wrap-around or saturating results;
- compare each pair of lanes for equality and return an all-ones or all-zeros mask per lane;
- apply AND, OR or XOR across the whole 64-bit word.

No carry or borrow ever crosses a lane boundary.

The block has a single register stage. An operation presented with `valid_i` high is captured at the next rising clock edge. Its result appears on `res_o`, with `valid_o` high, for the following cycle. When `valid_i` is low, `res_o` keeps its last value. Saturation is defined only for byte and word lanes. When a saturating operation is requested with 32-bit lanes, it returns the wrap-around result.

Top module: `simd_alu_unit`

## Requirements
- R1: While `rst_ni` is low, `res_o` is 0 and `valid_o` is 0.
- R2: `valid_o` is `valid_i` delayed by one clock. The result of an operation accepted at one edge is on `res_o` after that edge. `res_o` holds its value in any cycle in which `valid_i` was low at the edge.
- R3: `size_i` selects the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes, and 2 or 3 give 32-bit lanes. Opcode 0 adds each lane pair modulo 2^width. Opcode 1 computes a−b modulo 2^width in each lane. Carries and borrows never cross lane boundaries.
- R4: Opcode 2 is an unsigned saturating add. A lane whose true sum exceeds 2^width−1 returns all ones.
- R5: Opcode 3 is an unsigned saturating subtract. A lane where b > a returns zero.
- R6: Opcode 4 is a signed saturating add and opcode 5 is a signed saturating subtract. A two's-complement lane result above the most positive value returns 0111…1. A result below the most negative value returns 1000…0.
- R7: With 32-bit lanes (`size_i` 2 or 3), opcodes 2 and 4 return the opcode 0 result, and opcodes 3 and 5 return the opcode 1 result.
- R8: Opcode 6 compares lanes for equality. Each lane of the result is all ones when the two lanes are equal and all zeros when they differ.
- R9: Opcodes 7, 8 and 9 return the bitwise AND, OR and XOR of the full 64-bit operands, for any `size_i`.
- R10: Opcodes 10 to 15 return a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code (see R3–R10) |
| size_i | input | 2 | Lane width select |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| valid_o | output | 1 | Result is new this cycle |
| res_o | output | 64 | Packed result |

## Verification
The hardest cases to reach are the ones at lane boundaries. One is a carry or borrow produced at the top of one lane, which must not reach its neighbour. The other is the sign-dependent clamp, where only the top byte of a saturated 16-bit lane takes 0x7F or 0x80. Random operands almost never create these.

The stimulus therefore uses directed operands built around 0x7F, 0x80, 0xFF and 0x00 at every byte position. Each directed operand pair is run through all sixteen opcodes and all four size codes. Random traffic and idle cycles with changing operands come after the directed set.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_ADDUS = 4'd2,
    OP_SUBUS = 4'd3,
    OP_ADDSS = 4'd4,
    OP_SUBSS = 4'd5,
    OP_CMPEQ = 4'd6,
    OP_AND   = 4'd7,
    OP_OR    = 4'd8,
    OP_XOR   = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_UNS  = 2'd1,
    SAT_SGN  = 2'd2
  } sat_e;

  // lane width expressed in segments
  function automatic logic [2:0] segs_per_lane(input logic [1:0] size);
    case (size)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/simd_split_adder.sv
module simd_split_adder #(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 8,
  localparam int NSEG  = DATA_W / SEG_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic [NSEG-1:0]   lane_start_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [NSEG-1:0]   cout_o,
  output logic [NSEG-1:0]   ovf_o
);
  always_comb begin
    logic            c;
    logic [SEG_W-1:0] as, bx;
    logic [SEG_W:0]   t;
    c      = sub_i;
    sum_o  = '0;
    cout_o = '0;
    ovf_o  = '0;
    for (int k = 0; k < NSEG; k++) begin
      if (lane_start_i[k]) c = sub_i;  // carry chain cut at lane start
      as = a_i[k*SEG_W +: SEG_W];
      bx = sub_i ? ~b_i[k*SEG_W +: SEG_W] : b_i[k*SEG_W +: SEG_W];
      t  = {1'b0, as} + {1'b0, bx} + {{SEG_W{1'b0}}, c};
      sum_o[k*SEG_W +: SEG_W] = t[SEG_W-1:0];
      cout_o[k] = t[SEG_W];
      ovf_o[k]  = (as[SEG_W-1] == bx[SEG_W-1]) && (t[SEG_W-1] != as[SEG_W-1]);
      c = t[SEG_W];
    end
  end
endmodule

// File: rtl/simd_saturate.sv
module simd_saturate
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 8,
  localparam int NSEG  = DATA_W / SEG_W
) (
  input  logic [DATA_W-1:0] sum_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [NSEG-1:0]   cout_i,
  input  logic [NSEG-1:0]   ovf_i,
  input  logic              sub_i,
  input  sat_e              mode_i,
  input  logic [2:0]        spl_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    int   top;
    logic hit, neg, last;
    logic [SEG_W-1:0] val;
    res_o = sum_i;
    for (int k = 0; k < NSEG; k++) begin
      top  = k | (int'(spl_i) - 1);   // lane flags live in its top segment
      last = (k == top);
      neg  = a_i[top*SEG_W + SEG_W-1];
      hit  = 1'b0;
      val  = '0;
      case (mode_i)
        SAT_UNS: begin
          hit = sub_i ? ~cout_i[top] : cout_i[top];
          val = sub_i ? '0 : '1;
        end
        SAT_SGN: begin
          hit = ovf_i[top];
          if (last) val = neg ? {1'b1, {(SEG_W-1){1'b0}}} : {1'b0, {(SEG_W-1){1'b1}}};
          else      val = neg ? '0 : '1;
        end
        default: hit = 1'b0;
      endcase
      if (hit) res_o[k*SEG_W +: SEG_W] = val;
    end
  end
endmodule

// File: rtl/simd_cmpeq.sv
module simd_cmpeq #(
  parameter int DATA_W  = 64,
  parameter int SEG_W   = 8,
  parameter int MAX_SPL = 4,
  localparam int NSEG   = DATA_W / SEG_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        spl_i,
  output logic [DATA_W-1:0] mask_o
);
  logic [NSEG-1:0] seg_eq;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    assign seg_eq[k] = (a_i[k*SEG_W +: SEG_W] == b_i[k*SEG_W +: SEG_W]);
  end

  always_comb begin
    int   base;
    logic eq;
    mask_o = '0;
    for (int k = 0; k < NSEG; k++) begin
      base = k & ~(int'(spl_i) - 1);
      eq   = 1'b1;
      for (int j = 0; j < MAX_SPL; j++)
        if (j < int'(spl_i) && (base + j) < NSEG) eq = eq & seg_eq[base + j];
      mask_o[k*SEG_W +: SEG_W] = {SEG_W{eq}};
    end
  end
endmodule

// File: rtl/simd_alu_unit.sv
module simd_alu_unit
  import simd_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int SEG_W       = 8,
  parameter int SAT_MAX_SPL = 2,
  localparam int NSEG       = DATA_W / SEG_W,
  localparam int MAX_SPL    = 32 / SEG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o
);
  op_e               op;
  logic [2:0]        spl;
  logic [NSEG-1:0]   lane_start;
  logic              sub;
  sat_e              sat_mode;
  logic [DATA_W-1:0] sum, sat_res, eq_mask;
  logic [NSEG-1:0]   cout, ovf;
  logic [DATA_W-1:0] res_d;

  assign op  = op_e'(op_i);
  assign spl = segs_per_lane(size_i);

  for (genvar k = 0; k < NSEG; k++) begin : g_start
    assign lane_start[k] = ((k & (int'(spl) - 1)) == 0);
  end

  assign sub = (op == OP_SUB) || (op == OP_SUBUS) || (op == OP_SUBSS);

  always_comb begin
    sat_mode = SAT_NONE;
    if (int'(spl) <= SAT_MAX_SPL) begin  // wide lanes: wrap-around only
      if (op == OP_ADDUS || op == OP_SUBUS) sat_mode = SAT_UNS;
      if (op == OP_ADDSS || op == OP_SUBSS) sat_mode = SAT_SGN;
    end
  end

  simd_split_adder #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_adder (
    .a_i(a_i), .b_i(b_i), .sub_i(sub), .lane_start_i(lane_start),
    .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  simd_saturate #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_sat (
    .sum_i(sum), .a_i(a_i), .cout_i(cout), .ovf_i(ovf), .sub_i(sub),
    .mode_i(sat_mode), .spl_i(spl), .res_o(sat_res)
  );

  simd_cmpeq #(.DATA_W(DATA_W), .SEG_W(SEG_W), .MAX_SPL(MAX_SPL)) u_cmp (
    .a_i(a_i), .b_i(b_i), .spl_i(spl), .mask_o(eq_mask)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_ADDUS, OP_SUBUS, OP_ADDSS, OP_SUBSS: res_d = sat_res;
      OP_CMPEQ: res_d = eq_mask;
      OP_AND:   res_d = a_i & b_i;
      OP_OR:    res_d = a_i | b_i;
      OP_XOR:   res_d = a_i ^ b_i;
      default:  res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= res_d;
    end
  end

  // ---------------- assertions ----------------
  function automatic logic all_seg_mask(input logic [DATA_W-1:0] v);
    for (int k = 0; k < NSEG; k++)
      if (v[k*SEG_W +: SEG_W] != '0 && v[k*SEG_W +: SEG_W] != '1) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic seg_ge(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    for (int k = 0; k < NSEG; k++)
      if (x[k*SEG_W +: SEG_W] < y[k*SEG_W +: SEG_W]) return 1'b0;
    return 1'b1;
  endfunction

  assert_valid_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));

  assert_adds_floor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd2 && size_i == 2'd0 |=> seg_ge(res_o, $past(a_i)));

  assert_subs_ceiling_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd3 && size_i == 2'd0 |=> seg_ge($past(a_i), res_o));

  assert_wide_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == 4'd2 || op_i == 4'd4) && size_i[1] |=>
      res_o == {$past(a_i[63:32]) + $past(b_i[63:32]), $past(a_i[31:0]) + $past(b_i[31:0])});

  assert_mask_form_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd6 |=> all_seg_mask(res_o));

  assert_xor_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd9 |=> res_o == $past(a_i ^ b_i));

  assert_undef_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i >= 4'd10 |=> res_o == '0);
endmodule

// File: tb/simd_alu_unit_bench.sv
module simd_alu_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  size = '0;
  logic [63:0] a = '0, b = '0;
  logic        valid_o;
  logic [63:0] res_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] last_exp = '0;
  bit          done = 0;

  always #4 clk = ~clk;  // 125 MHz

  simd_alu_unit u_simd_alu_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .size_i(size),
    .a_i(a), .b_i(b), .valid_o(valid_o), .res_o(res_o)
  );

  function automatic logic [63:0] model(input logic [3:0] o, input logic [1:0] s,
                                        input logic [63:0] x, input logic [63:0] y);
    int wl, n;
    logic [63:0] m, r, xv, yv, v;
    longint xs, ys, t, hi, lo;
    if (o == 4'd7) return x & y;
    if (o == 4'd8) return x | y;
    if (o == 4'd9) return x ^ y;
    if (o >= 4'd10) return '0;
    wl = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    n  = 64 / wl;
    m  = (64'd1 << wl) - 64'd1;
    hi = (longint'(1) << (wl - 1)) - 1;
    lo = -(longint'(1) << (wl - 1));
    r  = '0;
    for (int i = 0; i < n; i++) begin
      xv = (x >> (i * wl)) & m;
      yv = (y >> (i * wl)) & m;
      xs = ((xv >> (wl - 1)) & 64'd1) != 0 ? longint'(xv) - (longint'(1) << wl) : longint'(xv);
      ys = ((yv >> (wl - 1)) & 64'd1) != 0 ? longint'(yv) - (longint'(1) << wl) : longint'(yv);
      case (o)
        4'd0: v = (xv + yv) & m;
        4'd1: v = (xv - yv) & m;
        4'd2: v = (wl == 32) ? ((xv + yv) & m) : ((xv + yv > m) ? m : xv + yv);
        4'd3: v = (wl == 32) ? ((xv - yv) & m) : ((xv < yv) ? 64'd0 : xv - yv);
        4'd4, 4'd5: begin
          t = (o == 4'd4) ? xs + ys : xs - ys;
          if (wl != 32) begin
            if (t > hi) t = hi;
            if (t < lo) t = lo;
          end
          v = 64'(t) & m;
        end
        default: v = (xv == yv) ? m : 64'd0;
      endcase
      r = r | (v << (i * wl));
    end
    return r;
  endfunction

  function automatic string req_of(input logic [3:0] o, input logic [1:0] s);
    if (o <= 4'd1) return "R3";
    if (o <= 4'd5 && s[1]) return "R7";
    case (o)
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4, 4'd5: return "R6";
      4'd6: return "R8";
      4'd7, 4'd8, 4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic drive(input logic [3:0] o, input logic [1:0] s,
                       input logic [63:0] x, input logic [63:0] y);
    @(negedge clk);
    valid = 1'b1; op = o; size = s; a = x; b = y;
    exp_q.push_back(model(o, s, x, y));
    tag_q.push_back(req_of(o, s));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b0; a = {$urandom, $urandom}; b = {$urandom, $urandom}; op = 4'($urandom);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n) begin
        checks++;
        if (valid_o) begin
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R2: unexpected valid_o, res=%h expected none", res_o);
          end else begin
            logic [63:0] e;
            string tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            last_exp = e;
            if (res_o !== e) begin
              errors++;
              $display("FAIL %s: res=%h expected %h", tg, res_o, e);
            end
          end
        end else if (res_o !== last_exp) begin  // R2 hold while idle
          errors++;
          $display("FAIL R2: held res=%h expected %h", res_o, last_exp);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] va[6], vb[6];
    va[0] = 64'h00FF_00FF_7F80_FFFF; vb[0] = 64'h0001_0001_0101_0001;
    va[1] = 64'h7FFF_8000_0000_7F7F; vb[1] = 64'h0001_0001_0001_0101;
    va[2] = 64'h8000_0000_FFFF_FFFF; vb[2] = 64'h7FFF_FFFF_0000_0001;
    va[3] = 64'h1234_5678_9ABC_DEF0; vb[3] = 64'h1234_5600_9ABC_0000;
    va[4] = 64'h0000_0000_0080_0000; vb[4] = 64'hFFFF_FFFF_0001_0001;
    va[5] = 64'h8080_8080_7F7F_7F7F; vb[5] = 64'h7F80_0180_7F01_FF80;

    repeat (3) @(negedge clk);
    checks++;  // R1 reset state
    if (res_o !== 64'd0 || valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: res=%h valid=%b expected 0 0", res_o, valid_o);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    for (int v = 0; v < 6; v++)
      for (int o = 0; o < 16; o++)
        for (int s = 0; s < 4; s++)
          drive(4'(o), 2'(s), va[v], vb[v]);
    idle(5);
    for (int i = 0; i < 600; i++) begin
      drive(4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
            {$urandom, $urandom}, {$urandom, $urandom});
      if (i % 50 == 0) idle(3);
    end
    idle(6);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d results missing, expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1;
    $finish;
  end
endmodule